// File: doc/BRIEF.md
# Configuration Port Site Switch Sequencer

This block hands internal configuration-port access over from one of two physical port sites to the other. The two sites share one configuration engine. Only one of them may be active at any time, and the top site is active when reset ends. When the block gets a switch request, it writes a fixed series of 32-bit configuration words through the site that is active now. That series synchronises the port, unlocks and sets the site-select control bit, and desynchronises. The block then synchronises the newly selected site and raises a one-cycle done pulse.

When no switch is in progress, the block passes a user access path through to the active site. That path has an enable, a write/read select and a write data bus, and the active site's read data bus is returned to the user. The bus width is a parameter of 8 or 32 bits. At 8 bits, each 32-bit word is sent most significant byte first, and the bit order within each byte is reversed. At 32 bits, each word goes out unchanged in a single cycle.

Top module: `cfg_site_switcher`

## Requirements
- R1: After reset the top site (cur_site = 0) is active, sw_busy and sw_done are 0, and the bottom site's enable is 0.
- R2: top_en and bot_en are never 1 in the same cycle.
- R3: An accepted switch drives ten words, each with enable and write select at 1, in this order: 0xAA995566, 0x20000000, 0x3000C001, 0x40000000, 0x3000A001, site word, 0x30008001, 0x0000000D, 0xAA995566, 0x20000000. Each header word holds 001 in bits 31:29, 10 (write) in bits 28:27, the register address in bits 17:13 (command 0x04, control 0x05, mask 0x06) and a count of 1 in bits 10:0.
- R4: The site word, which is the sixth word, is 0x40000000 when switching to the bottom site and 0x00000000 when switching to the top site.
- R5: With BUS_W = 8, each word takes four cycles, bits 31:24 first. Every byte is bit-reversed: output bit i equals source bit 7-i of that byte. With BUS_W = 32, each word takes one cycle and is unchanged.
- R6: The first eight words go to the site that was active at the request and the last two go to the new site. cur_site changes at the clock edge that ends the final beat of 0x0000000D. Enable, write select and data of the inactive site stay 0.
- R7: sw_busy is 1 from the cycle after an accepted request through the last beat. sw_done is 1 for exactly the one cycle that follows the last beat.
- R8: A request naming the site that is already active drives no words. It gives sw_done = 1 in the next cycle with sw_busy still 0.
- R9: While not busy, usr_en, usr_wr and usr_din drive the active site's enable, write select and data. While busy they are ignored. usr_dout always returns the active site's read data.
- R10: A request arriving while busy is ignored and does not alter the sequence in progress or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_req | input | 1 | Switch request, sampled when idle |
| sw_target | input | 1 | Requested site: 0 top, 1 bottom |
| sw_busy | output | 1 | Switch sequence in progress |
| sw_done | output | 1 | One-cycle completion pulse |
| cur_site | output | 1 | Active site: 0 top, 1 bottom |
| usr_en | input | 1 | User port enable |
| usr_wr | input | 1 | User write select (1 write, 0 read) |
| usr_din | input | BUS_W | User write data |
| usr_dout | output | BUS_W | Read data from the active site |
| top_en | output | 1 | Top site enable |
| top_wr | output | 1 | Top site write select |
| top_din | output | BUS_W | Top site write data |
| top_dout | input | BUS_W | Top site read data |
| bot_en | output | 1 | Bottom site enable |
| bot_wr | output | 1 | Bottom site write select |
| bot_din | output | BUS_W | Bottom site write data |
| bot_dout | input | BUS_W | Bottom site read data |

## Verification
The bench targets the moment cur_site flips. If the flip came one beat early or late, the desynchronise word or the first new sync word would land on the wrong site. The bench runs switches in both directions, so a site word with a constant bit 30 is caught. It also compares byte order and bit reversal against an 8-bit and a 32-bit instance side by side. Further stimulus covers a same-site request, a request and user traffic arriving during a switch, and a reset in mid-sequence. A design that got these wrong would write spurious words, restart the sequence, or leak user traffic into the handover.

// File: rtl/cfg_swap_pkg.sv
package cfg_swap_pkg;

   // Number of words in one full handover and the index of the last word sent
   // through the site that was active when the request arrived.
   localparam int SEQ_LEN       = 10;
   localparam int LAST_OLD_WORD = 7;
   localparam int SITE_BIT      = 30;

   localparam logic [31:0] SYNC_WORD   = 32'hAA995566;
   localparam logic [31:0] NOOP_WORD   = 32'h20000000;
   localparam logic [31:0] DESYNC_CODE = 32'h0000000D;

   localparam logic [4:0] ADDR_CMD  = 5'h04;
   localparam logic [4:0] ADDR_CTL  = 5'h05;
   localparam logic [4:0] ADDR_MASK = 5'h06;

   typedef enum logic {SITE_TOP = 1'b0, SITE_BOT = 1'b1} site_t;
   typedef enum logic {ST_IDLE = 1'b0, ST_SEND = 1'b1} seq_state_t;

   // Single-word write header: type 1, write opcode, register address, count 1.
   function automatic logic [31:0] wr_header(input logic [4:0] addr);
      return {3'b001, 2'b10, 9'd0, addr, 2'b00, 11'd1};
   endfunction

endpackage

// File: rtl/swap_word_table.sv
module swap_word_table
   import cfg_swap_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic [IDX_W-1:0] word_idx,
   input  logic             tgt_site,
   output logic [31:0]      word
);

   logic [31:0] site_word;

   always_comb begin
      site_word           = '0;
      site_word[SITE_BIT] = tgt_site;
   end

   always_comb begin
      case (int'(word_idx))
         0:       word = SYNC_WORD;
         1:       word = NOOP_WORD;
         2:       word = wr_header(ADDR_MASK);
         3:       word = 32'(1) << SITE_BIT;
         4:       word = wr_header(ADDR_CTL);
         5:       word = site_word;
         6:       word = wr_header(ADDR_CMD);
         7:       word = DESYNC_CODE;
         8:       word = SYNC_WORD;
         default: word = NOOP_WORD;
      endcase
   end

endmodule

// File: rtl/swap_lane_slicer.sv
module swap_lane_slicer #(
   parameter int BUS_W  = 8,
   parameter int BEAT_W = 2
) (
   input  logic [31:0]       word,
   input  logic [BEAT_W-1:0] beat,
   output logic [BUS_W-1:0]  lane
);

   logic [31:0]      shifted;
   logic [BUS_W-1:0] chunk;

   // Beat 0 carries the most significant lane.
   assign shifted = word << (32'(beat) * 32'(BUS_W));
   assign chunk   = shifted[31 -: BUS_W];

   generate
      if (BUS_W == 8) begin : g_reverse
         always_comb begin
            for (int i = 0; i < BUS_W; i++) begin
               lane[i] = chunk[BUS_W-1-i];
            end
         end
      end else begin : g_straight
         assign lane = chunk;
      end
   endgenerate

endmodule

// File: rtl/swap_site_router.sv
module swap_site_router #(
   parameter int BUS_W = 8
) (
   input  logic             act_site,
   input  logic             seq_busy,
   input  logic [BUS_W-1:0] seq_din,
   input  logic             usr_en,
   input  logic             usr_wr,
   input  logic [BUS_W-1:0] usr_din,
   output logic [BUS_W-1:0] usr_dout,
   output logic             top_en,
   output logic             top_wr,
   output logic [BUS_W-1:0] top_din,
   input  logic [BUS_W-1:0] top_dout,
   output logic             bot_en,
   output logic             bot_wr,
   output logic [BUS_W-1:0] bot_din,
   input  logic [BUS_W-1:0] bot_dout
);

   localparam int NSITE = 2;

   logic             src_en;
   logic             src_wr;
   logic [BUS_W-1:0] src_din;
   logic             site_en  [NSITE];
   logic             site_wr  [NSITE];
   logic [BUS_W-1:0] site_din [NSITE];

   // The sequencer owns the port while busy; otherwise the user path does.
   assign src_en  = seq_busy ? 1'b1 : usr_en;
   assign src_wr  = seq_busy ? 1'b1 : usr_wr;
   assign src_din = seq_busy ? seq_din : usr_din;

   generate
      for (genvar s = 0; s < NSITE; s++) begin : g_site
         logic picked;
         assign picked      = (act_site == 1'(s));
         assign site_en[s]  = picked & src_en;
         assign site_wr[s]  = picked & src_wr;
         assign site_din[s] = picked ? src_din : '0;
      end
   endgenerate

   assign top_en   = site_en[0];
   assign top_wr   = site_wr[0];
   assign top_din  = site_din[0];
   assign bot_en   = site_en[1];
   assign bot_wr   = site_wr[1];
   assign bot_din  = site_din[1];
   assign usr_dout = act_site ? bot_dout : top_dout;

endmodule

// File: rtl/cfg_site_switcher.sv
module cfg_site_switcher
   import cfg_swap_pkg::*;
#(
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_req,
   input  logic             sw_target,
   output logic             sw_busy,
   output logic             sw_done,
   output logic             cur_site,
   input  logic             usr_en,
   input  logic             usr_wr,
   input  logic [BUS_W-1:0] usr_din,
   output logic [BUS_W-1:0] usr_dout,
   output logic             top_en,
   output logic             top_wr,
   output logic [BUS_W-1:0] top_din,
   input  logic [BUS_W-1:0] top_dout,
   output logic             bot_en,
   output logic             bot_wr,
   output logic [BUS_W-1:0] bot_din,
   input  logic [BUS_W-1:0] bot_dout
);

   localparam int BEATS  = 32 / BUS_W;
   localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam int IDX_W  = $clog2(SEQ_LEN);
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
   localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(SEQ_LEN - 1);
   localparam logic [IDX_W-1:0]  FLIP_IDX  = IDX_W'(LAST_OLD_WORD);

   generate
      if (BUS_W != 8 && BUS_W != 32) begin : g_bad_width
         $error("cfg_site_switcher: BUS_W must be 8 or 32");
      end
   endgenerate

   seq_state_t        state;
   logic [IDX_W-1:0]  word_idx;
   logic [BEAT_W-1:0] beat_idx;
   logic              act_site;
   logic              tgt_site;
   logic              done_q;
   logic [31:0]       cur_word;
   logic [BUS_W-1:0]  seq_lane;
   logic              last_beat;

   assign last_beat = (beat_idx == LAST_BEAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         word_idx <= '0;
         beat_idx <= '0;
         act_site <= SITE_TOP;
         tgt_site <= SITE_TOP;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (sw_req) begin
                  if (sw_target == act_site) begin
                     done_q <= 1'b1;
                  end else begin
                     state    <= ST_SEND;
                     tgt_site <= sw_target;
                     word_idx <= '0;
                     beat_idx <= '0;
                  end
               end
            end
            default: begin
               if (last_beat) begin
                  beat_idx <= '0;
                  if (word_idx == FLIP_IDX) begin
                     act_site <= tgt_site;
                  end
                  if (word_idx == LAST_IDX) begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     word_idx <= word_idx + 1'b1;
                  end
               end else begin
                  beat_idx <= beat_idx + 1'b1;
               end
            end
         endcase
      end
   end

   swap_word_table #(.IDX_W(IDX_W)) u_table (
      .word_idx (word_idx),
      .tgt_site (tgt_site),
      .word     (cur_word)
   );

   swap_lane_slicer #(.BUS_W(BUS_W), .BEAT_W(BEAT_W)) u_slicer (
      .word (cur_word),
      .beat (beat_idx),
      .lane (seq_lane)
   );

   swap_site_router #(.BUS_W(BUS_W)) u_router (
      .act_site (act_site),
      .seq_busy (sw_busy),
      .seq_din  (seq_lane),
      .usr_en   (usr_en),
      .usr_wr   (usr_wr),
      .usr_din  (usr_din),
      .usr_dout (usr_dout),
      .top_en   (top_en),
      .top_wr   (top_wr),
      .top_din  (top_din),
      .top_dout (top_dout),
      .bot_en   (bot_en),
      .bot_wr   (bot_wr),
      .bot_din  (bot_din),
      .bot_dout (bot_dout)
   );

   assign sw_busy  = (state == ST_SEND);
   assign sw_done  = done_q;
   assign cur_site = act_site;

endmodule

// File: rtl/cfg_site_switcher_chk.sv
module cfg_site_switcher_chk (
   input logic clk,
   input logic rst_n,
   input logic sw_req,
   input logic sw_target,
   input logic sw_busy,
   input logic sw_done,
   input logic cur_site,
   input logic top_en,
   input logic top_wr,
   input logic bot_en,
   input logic bot_wr
);

   AST_RESET_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cur_site == 1'b0 && !sw_busy && !sw_done)); // R1

   AST_SITE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(top_en && bot_en)); // R2

   AST_BUSY_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      sw_busy |-> ((top_en || bot_en) && (top_wr || bot_wr))); // R3

   AST_TOP_EN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      top_en |-> (cur_site == 1'b0)); // R6

   AST_BOT_EN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      bot_en |-> (cur_site == 1'b1)); // R6

   AST_SITE_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_busy && !$past(sw_busy)) |-> $stable(cur_site)); // R6

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      sw_done |-> !sw_busy); // R7

   AST_SAME_SITE_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_busy && sw_req && sw_target == cur_site) |=> (sw_done && !sw_busy)); // R8

   AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_busy && sw_req && !sw_done) |=> !sw_done || !sw_busy); // R10

endmodule

bind cfg_site_switcher cfg_site_switcher_chk u_chk (.*);

// File: tb/cfg_site_switcher_test.sv
`timescale 1ns/1ps

module cfg_site_switcher_ref #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req,
   input  logic         target,
   input  logic         u_en,
   input  logic         u_wr,
   input  logic [W-1:0] u_din,
   input  logic [W-1:0] t_dout,
   input  logic [W-1:0] b_dout,
   input  logic         d_busy,
   input  logic         d_done,
   input  logic         d_site,
   input  logic [W-1:0] d_udout,
   input  logic         d_ten,
   input  logic         d_twr,
   input  logic [W-1:0] d_tdin,
   input  logic         d_ben,
   input  logic         d_bwr,
   input  logic [W-1:0] d_bdin,
   output int           n_chk,
   output int           n_bad
);

   typedef struct {
      bit           site;
      logic [W-1:0] data;
      bit           flip;
      int           widx;
   } beat_t;

   beat_t q[$];
   bit    m_act;
   bit    m_done;

   initial begin
      n_chk = 0;
      n_bad = 0;
   end

   function automatic logic [W-1:0] lane_of(input logic [31:0] w, input int k);
      logic [7:0] b;
      logic [7:0] r;
      if (W == 32) return W'(w);
      b = w[31-8*k -: 8];
      for (int i = 0; i < 8; i++) r[i] = b[7-i];
      return W'(r);
   endfunction

   task automatic build(input bit tgt);
      logic [31:0] words [10];
      beat_t       b;
      int          nb;
      nb = 32 / W;
      words[0] = 32'hAA995566;  words[1] = 32'h20000000;
      words[2] = 32'h3000C001;  words[3] = 32'h40000000;
      words[4] = 32'h3000A001;  words[5] = tgt ? 32'h40000000 : 32'h0;
      words[6] = 32'h30008001;  words[7] = 32'h0000000D;
      words[8] = 32'hAA995566;  words[9] = 32'h20000000;
      for (int w = 0; w < 10; w++) begin
         for (int k = 0; k < nb; k++) begin
            b.site = (w < 8) ? m_act : tgt;
            b.data = lane_of(words[w], k);
            b.flip = (w == 7 && k == nb - 1);
            b.widx = w;
            q.push_back(b);
         end
      end
   endtask

   task automatic cmp(input string tag, input logic [63:0] a, input logic [63:0] e);
      n_chk++;
      if (a !== e) begin
         n_bad++;
         $display("FAIL %s (W=%0d) t=%0t actual=%h expected=%h", tag, W, $time, a, e);
      end
   endtask

   always @(posedge clk) begin
      beat_t b;
      if (!rst_n) begin
         q.delete();
         m_act  = 1'b0;
         m_done = 1'b0;
      end else begin
         m_done = 1'b0;
         if (q.size() > 0) begin
            b = q.pop_front();
            if (b.flip) m_act = ~m_act;
            if (q.size() == 0) m_done = 1'b1;
         end else if (req) begin
            if (target == m_act) m_done = 1'b1;
            else build(target);
         end
      end
      #15;
      if (rst_n) begin
         string dtag;
         cmp("R6", 64'(d_site), 64'(m_act));
         cmp("R7", 64'(d_busy), 64'(q.size() > 0));
         cmp("R7", 64'(d_done), 64'(m_done));
         cmp("R2", 64'(d_ten & d_ben), 64'(0));
         cmp("R9", 64'(d_udout), 64'(m_act ? b_dout : t_dout));
         if (q.size() > 0) begin
            b = q[0];
            if (b.widx == 5) dtag = "R4";
            else if (W == 8) dtag = "R5";
            else dtag = "R3";
            cmp("R6", 64'(d_ten), 64'(b.site == 1'b0));
            cmp("R6", 64'(d_ben), 64'(b.site == 1'b1));
            cmp("R3", 64'(b.site ? d_bwr : d_twr), 64'(1));
            cmp(dtag, 64'(b.site ? d_bdin : d_tdin), 64'(b.data));
            cmp("R6", 64'(b.site ? d_tdin : d_bdin), 64'(0));
            cmp("R6", 64'(b.site ? d_twr : d_bwr), 64'(0));
         end else begin
            cmp("R9", 64'(m_act ? d_ben : d_ten), 64'(u_en));
            cmp("R9", 64'(m_act ? d_bwr : d_twr), 64'(u_wr));
            cmp("R9", 64'(m_act ? d_bdin : d_tdin), 64'(u_din));
            cmp("R9", 64'(m_act ? d_ten : d_ben), 64'(0));
            cmp("R9", 64'(m_act ? d_tdin : d_bdin), 64'(0));
         end
      end
   end

endmodule

module cfg_site_switcher_test;

   localparam real PERIOD = 20.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        target = 1'b0;
   logic        u_en = 1'b0;
   logic        u_wr = 1'b0;
   logic [31:0] u_din = '0;
   logic [31:0] t_dout = 32'h1234_5678;
   logic [31:0] b_dout = 32'h9ABC_DEF0;

   logic        a_busy, a_done, a_site, a_ten, a_twr, a_ben, a_bwr;
   logic [7:0]  a_udout, a_tdin, a_bdin;
   logic        c_busy, c_done, c_site, c_ten, c_twr, c_ben, c_bwr;
   logic [31:0] c_udout, c_tdin, c_bdin;

   int ra_chk, ra_bad, rc_chk, rc_bad;
   int t_chk = 0;
   int t_bad = 0;

   always #(PERIOD/2) clk = ~clk;

   cfg_site_switcher #(.BUS_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .sw_req(req), .sw_target(target),
      .sw_busy(a_busy), .sw_done(a_done), .cur_site(a_site),
      .usr_en(u_en), .usr_wr(u_wr), .usr_din(u_din[7:0]), .usr_dout(a_udout),
      .top_en(a_ten), .top_wr(a_twr), .top_din(a_tdin), .top_dout(t_dout[7:0]),
      .bot_en(a_ben), .bot_wr(a_bwr), .bot_din(a_bdin), .bot_dout(b_dout[7:0])
   );

   cfg_site_switcher #(.BUS_W(32)) uut_w32 (
      .clk(clk), .rst_n(rst_n), .sw_req(req), .sw_target(target),
      .sw_busy(c_busy), .sw_done(c_done), .cur_site(c_site),
      .usr_en(u_en), .usr_wr(u_wr), .usr_din(u_din), .usr_dout(c_udout),
      .top_en(c_ten), .top_wr(c_twr), .top_din(c_tdin), .top_dout(t_dout),
      .bot_en(c_ben), .bot_wr(c_bwr), .bot_din(c_bdin), .bot_dout(b_dout)
   );

   cfg_site_switcher_ref #(.W(8)) ref_a (
      .clk(clk), .rst_n(rst_n), .req(req), .target(target),
      .u_en(u_en), .u_wr(u_wr), .u_din(u_din[7:0]),
      .t_dout(t_dout[7:0]), .b_dout(b_dout[7:0]),
      .d_busy(a_busy), .d_done(a_done), .d_site(a_site), .d_udout(a_udout),
      .d_ten(a_ten), .d_twr(a_twr), .d_tdin(a_tdin),
      .d_ben(a_ben), .d_bwr(a_bwr), .d_bdin(a_bdin),
      .n_chk(ra_chk), .n_bad(ra_bad)
   );

   cfg_site_switcher_ref #(.W(32)) ref_c (
      .clk(clk), .rst_n(rst_n), .req(req), .target(target),
      .u_en(u_en), .u_wr(u_wr), .u_din(u_din),
      .t_dout(t_dout), .b_dout(b_dout),
      .d_busy(c_busy), .d_done(c_done), .d_site(c_site), .d_udout(c_udout),
      .d_ten(c_ten), .d_twr(c_twr), .d_tdin(c_tdin),
      .d_ben(c_ben), .d_bwr(c_bwr), .d_bdin(c_bdin),
      .n_chk(rc_chk), .n_bad(rc_bad)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic tcheck(input string tag, input logic [63:0] a, input logic [63:0] e);
      t_chk++;
      if (a !== e) begin
         t_bad++;
         $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, a, e);
      end
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200; i++) begin
         if (!a_busy && !c_busy) break;
         tick();
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==",
               t_chk + ra_chk + rc_chk, t_bad + ra_bad + rc_bad);
      $finish;
   endtask

   initial begin
      #(PERIOD * 50000);
      t_chk++;
      t_bad++;
      $display("FAIL R7 watchdog expired actual=busy expected=idle");
      summary();
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1: reset state of both widths
      tcheck("R1", {a_site, a_busy, a_done, a_ben}, 4'b0000);
      tcheck("R1", {c_site, c_busy, c_done, c_ben}, 4'b0000);

      // R9: user passthrough on top site
      u_en = 1'b1; u_wr = 1'b1; u_din = 32'hA5C3_0F81;
      tick();
      u_wr = 1'b0; u_din = 32'h0000_003C; t_dout = 32'hCAFE_F00D;
      tick();
      u_en = 1'b0;
      tick();

      // R8: request for the site already active
      req = 1'b1; target = 1'b0;
      tick();
      req = 1'b0;
      tcheck("R8", {a_done, a_busy, a_ten, a_ben}, 4'b1000);
      tcheck("R8", {c_done, c_busy, c_ten, c_ben}, 4'b1000);
      tick();

      // Switch to bottom; user traffic and a stray request during the run
      req = 1'b1; target = 1'b1;
      tick();
      req = 1'b0;
      u_en = 1'b1; u_wr = 1'b1; u_din = 32'hFFFF_FFFF;
      repeat (3) tick();
      req = 1'b1; target = 1'b0;
      tick();
      req = 1'b0;
      u_en = 1'b0;
      wait_idle();
      tick();
      tcheck("R10", {a_site, c_site}, 2'b11);

      // R9: passthrough now lands on bottom
      u_en = 1'b1; u_wr = 1'b0; u_din = 32'h5A5A_5A5A; b_dout = 32'h0BAD_BEEF;
      repeat (2) tick();
      u_en = 1'b0;
      req = 1'b1; target = 1'b1;
      tick();
      req = 1'b0;
      tcheck("R8", {a_done, c_done, a_site}, 3'b111);

      // Switch back to top (R4 site word of zero)
      req = 1'b1; target = 1'b0;
      tick();
      req = 1'b0;
      wait_idle();
      tick();
      tcheck("R6", {a_site, c_site}, 2'b00);

      // Reset in mid-sequence returns to R1 state
      req = 1'b1; target = 1'b1;
      tick();
      req = 1'b0;
      repeat (5) tick();
      rst_n = 1'b0;
      repeat (2) tick();
      rst_n = 1'b1;
      tick();
      tcheck("R1", {a_site, a_busy, c_site, c_busy}, 4'b0000);

      // Final full switch to bottom after reset
      req = 1'b1; target = 1'b1;
      tick();
      req = 1'b0;
      wait_idle();
      tick();
      tcheck("R6", {a_site, c_site}, 2'b11);
      repeat (3) tick();
      summary();
   end

endmodule